// File: doc/BRIEF.md
# Push-Button Ramp Code Generator for a DAC

This block produces a 12-bit straight-binary code for a voltage DAC and presents it to the converter's data port with a one-cycle write strobe. An internal level register holds the current code. Two push-button inputs change it: a press of the "up" button adds one, and a press of the "down" button subtracts one. The level stops at full scale and at zero and does not wrap. Each raw button line is synchronised and debounced, and only a debounced low-to-high transition counts as a press.

The DAC is refreshed on a fixed timebase. An up-counter runs from zero to a compare value supplied on an input and then restarts from zero. The compare value is a cycle count: at 125 MHz a 1 ms period needs a compare value of 124999. At the end of each period the current level is loaded into the output code register and the write strobe is raised for exactly one cycle. Between strobes the output code does not change, even if the level moves.

Top module: `ramp_dac_ctrl`

## Requirements
- R1: While reset is active, and after it is released, `dac_code_o` reads 0 and `dac_wr_o` is low. The first strobe after reset writes code 0.
- R2: `dac_wr_o` is high for one cycle in every `period_cmp_i`+1 clock cycles. With `period_cmp_i` = 0 it is high on every cycle.
- R3: `dac_code_o` changes only in a cycle in which `dac_wr_o` is high, and it then carries the level as it stood at the end of the period. A level change made between strobes stays invisible until the next strobe.
- R4: A debounced low-to-high transition on `btn_up_i` raises the level by exactly one. Codes are unsigned binary in bits 11..0, 0 to 4095.
- R5: A debounced low-to-high transition on `btn_dn_i` lowers the level by exactly one.
- R6: An up press at level 4095 leaves the level at 4095.
- R7: A down press at level 0 leaves the level at 0.
- R8: A button level that lasts fewer than DB_CYC consecutive synchronised cycles has no effect. A button held high for any length of time produces exactly one step.
- R9: When both buttons produce their press in the same cycle, the level does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. It is released synchronously inside the block. |
| btn_up_i | input | 1 | Raw "increase" button, active high, asynchronous |
| btn_dn_i | input | 1 | Raw "decrease" button, active high, asynchronous |
| period_cmp_i | input | TICK_W | Timebase compare value. The period is this value plus one, in clock cycles. |
| dac_code_o | output | 12 | Straight-binary code to the DAC data port |
| dac_wr_o | output | 1 | One-cycle write strobe that goes with a new `dac_code_o` |

## Verification
The timebase assertion assumes that `period_cmp_i` holds steady across the cycle after a strobe. The bench only changes the compare value when it reconfigures the period, and no check spans that change. The stepper and conditioner properties assume that button presses are separated by at least the debounce window plus the synchroniser depth. The bench therefore holds each press and each release for ten cycles, which is well above a four-cycle window. The glitch and the long-hold cases are the only places where the bench departs from that spacing on purpose. Simultaneous presses are driven on the same clock edge, so that the two conditioners, which are identical, emit their pulses in the same cycle.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  localparam int unsigned DAC_W   = 12;
  localparam int unsigned DAC_MAX = (1 << DAC_W) - 1;
  typedef logic [DAC_W-1:0] dac_code_t;
endpackage

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int unsigned TICK_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] cmp_i,
  output logic              tick_o
);
  logic [TICK_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q >= cmp_i);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: after a tick the count restarts, so the next cycle ticks only for compare 0
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && cmp_i != '0) |=> (!tick_o || cmp_i == '0));
endmodule

// File: rtl/btn_cond.sv
module btn_cond #(
  parameter int unsigned DB_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic rise_o
);
  localparam int unsigned CW = $clog2(DB_CYC + 1);

  logic [1:0]    sync_q;
  logic          stable_q, stable_d;
  logic [CW-1:0] dbc_q, dbc_d;
  logic          rise_q, rise_d;
  logic          diff, settle;

  always_comb begin
    diff     = sync_q[1] ^ stable_q;
    settle   = diff && (dbc_q == CW'(DB_CYC - 1));
    dbc_d    = (diff && !settle) ? dbc_q + 1'b1 : '0;
    stable_d = settle ? sync_q[1] : stable_q;
    rise_d   = settle && sync_q[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      stable_q <= 1'b0;
      dbc_q    <= '0;
      rise_q   <= 1'b0;
    end else begin
      sync_q   <= {sync_q[0], raw_i};
      stable_q <= stable_d;
      dbc_q    <= dbc_d;
      rise_q   <= rise_d;
    end
  end

  assign rise_o = rise_q;

  // R8: a held button yields a single-cycle press pulse
  a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/code_stepper.sv
module code_stepper
  import ramp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      inc_i,
  input  logic      dec_i,
  output dac_code_t lvl_o
);
  dac_code_t lvl_q, lvl_d;
  logic      at_top, at_floor;

  always_comb begin
    at_top   = (lvl_q == dac_code_t'(DAC_MAX));
    at_floor = (lvl_q == '0);
    lvl_d    = lvl_q;
    if (inc_i && !dec_i && !at_top)        lvl_d = lvl_q + 1'b1;
    else if (dec_i && !inc_i && !at_floor) lvl_d = lvl_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  assign lvl_o = lvl_q;

  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !dec_i && lvl_q != dac_code_t'(DAC_MAX)) |=> (lvl_q == $past(lvl_q) + 1'b1));
  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !inc_i && lvl_q != '0) |=> (lvl_q == $past(lvl_q) - 1'b1));
  a_r6_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == dac_code_t'(DAC_MAX) && !dec_i) |=> (lvl_q == dac_code_t'(DAC_MAX)));
  a_r7_hold_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == '0 && !inc_i) |=> (lvl_q == '0));
  a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i == dec_i) |=> $stable(lvl_q));
endmodule

// File: rtl/ramp_dac_ctrl.sv
module ramp_dac_ctrl
  import ramp_pkg::*;
#(
  parameter int unsigned TICK_W = 17,
  parameter int unsigned DB_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              btn_up_i,
  input  logic              btn_dn_i,
  input  logic [TICK_W-1:0] period_cmp_i,
  output logic [DAC_W-1:0]  dac_code_o,
  output logic              dac_wr_o
);
  localparam int unsigned NBTN = 2;

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [NBTN-1:0] raw_btn, btn_rise;
  logic            tick;
  dac_code_t       lvl;
  dac_code_t       code_q, code_d;
  logic            wr_q, wr_d;

  // reset asserts at once and is released two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign raw_btn = {btn_dn_i, btn_up_i};

  for (genvar g = 0; g < NBTN; g++) begin : g_btn
    btn_cond #(.DB_CYC(DB_CYC)) cond_i (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .raw_i  (raw_btn[g]),
      .rise_o (btn_rise[g])
    );
  end

  tick_timer #(.TICK_W(TICK_W)) timer_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cmp_i  (period_cmp_i),
    .tick_o (tick)
  );

  code_stepper stepper_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .inc_i (btn_rise[0]),
    .dec_i (btn_rise[1]),
    .lvl_o (lvl)
  );

  always_comb begin
    code_d = tick ? lvl : code_q;
    wr_d   = tick;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      code_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      code_q <= code_d;
      wr_q   <= wr_d;
    end
  end

  assign dac_code_o = code_q;
  assign dac_wr_o   = wr_q;

  // R3: the DAC code only moves together with a strobe
  a_r3_code_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !dac_wr_o |-> $stable(dac_code_o));
  // R1: outputs are cleared while the internal reset is held
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_int_n |-> (dac_code_o == '0 && !dac_wr_o));
endmodule

// File: tb/ramp_dac_ctrl_tb_top.sv
module ramp_dac_ctrl_tb_top;
  localparam int unsigned TW = 17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          btn_up, btn_dn;
  logic [TW-1:0] period_cmp;
  logic [11:0]   dac_code;
  logic          dac_wr;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  ramp_dac_ctrl #(.TICK_W(TW), .DB_CYC(4)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .btn_up_i     (btn_up),
    .btn_dn_i     (btn_dn),
    .period_cmp_i (period_cmp),
    .dac_code_o   (dac_code),
    .dac_wr_o     (dac_wr)
  );

  // {up, dn, expected code}; covers R4, R5, R7, R9
  localparam logic [13:0] VEC [0:7] = '{
    14'h2001, 14'h2002, 14'h2003, 14'h1002,
    14'h3002, 14'h1001, 14'h1000, 14'h1000
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic press(input bit up, input bit dn, input int hold);
    btn_up = up;
    btn_dn = dn;
    cycles(hold);
    btn_up = 1'b0;
    btn_dn = 1'b0;
    cycles(10);
  endtask

  task automatic wait_strobe(input string tag);
    int k = 0;
    @(negedge clk);
    while (!dac_wr && k < 1000) begin
      @(negedge clk);
      k++;
    end
    if (!dac_wr) chk(1'b0, tag, 0, 1);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int gap;
    rst_n = 1'b0; btn_up = 1'b0; btn_dn = 1'b0; period_cmp = TW'(49);
    cycles(3);
    chk(dac_code == 12'd0, "R1 code in reset", dac_code, 0);
    chk(dac_wr == 1'b0, "R1 strobe in reset", dac_wr, 0);
    rst_n = 1'b1;
    wait_strobe("R1 first strobe");
    chk(dac_code == 12'd0, "R1 first written code", dac_code, 0);

    // R2: period and strobe width
    gap = 0;
    @(negedge clk);
    chk(dac_wr == 1'b0, "R2 strobe width", dac_wr, 0);
    gap = 1;
    while (!dac_wr && gap < 500) begin
      @(negedge clk);
      gap++;
    end
    chk(gap == 50, "R2 period cycles", gap, 50);

    // table walk: R4 R5 R7 R9
    for (int v = 0; v < 8; v++) begin
      press(VEC[v][13], VEC[v][12], 10);
      wait_strobe("R4 R5 vector strobe");
      chk(dac_code == VEC[v][11:0], $sformatf("R4 R5 R7 R9 vector %0d", v),
          dac_code, VEC[v][11:0]);
    end

    // R3: level change hidden until next strobe
    wait_strobe("R3 sync strobe");
    press(1'b1, 1'b0, 10);
    chk(dac_code == 12'd0 && !dac_wr, "R3 code held between strobes", dac_code, 0);
    wait_strobe("R3 next strobe");
    chk(dac_code == 12'd1, "R3 code at next strobe", dac_code, 1);

    // R8: short glitch ignored, long hold gives one step
    press(1'b1, 1'b0, 2);
    wait_strobe("R8 glitch strobe");
    chk(dac_code == 12'd1, "R8 glitch ignored", dac_code, 1);
    press(1'b1, 1'b0, 120);
    wait_strobe("R8 hold strobe");
    chk(dac_code == 12'd2, "R8 long hold one step", dac_code, 2);

    // R2: compare 0 strobes every cycle
    period_cmp = '0;
    cycles(3);
    chk(dac_wr == 1'b1, "R2 cmp0 strobe a", dac_wr, 1);
    @(negedge clk);
    chk(dac_wr == 1'b1, "R2 cmp0 strobe b", dac_wr, 1);
    period_cmp = TW'(49);

    // R6: saturate at full scale
    for (int p = 0; p < 4100; p++) press(1'b1, 1'b0, 10);
    wait_strobe("R6 strobe");
    chk(dac_code == 12'd4095, "R6 saturate top", dac_code, 4095);
    press(1'b1, 1'b0, 10);
    wait_strobe("R6 strobe b");
    chk(dac_code == 12'd4095, "R6 stay top", dac_code, 4095);
    press(1'b0, 1'b1, 10);
    wait_strobe("R5 strobe");
    chk(dac_code == 12'd4094, "R5 step down from top", dac_code, 4094);

    // R1: reset mid-run
    rst_n = 1'b0;
    cycles(2);
    chk(dac_code == 12'd0 && !dac_wr, "R1 mid-run reset", dac_code, 0);
    rst_n = 1'b1;
    wait_strobe("R1 strobe after reset");
    chk(dac_code == 12'd0, "R1 level cleared", dac_code, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule